// File: doc/BRIEF.md
# Programmable Display Line Pulse Generator

This block produces four horizontal-rate control pulses for the display side of a scan converter: horizontal blanking, memory write enable, memory read enable and horizontal display. Each pulse has its own rising and falling position within the display line. A position is built from a 9-bit coarse value, multiplied by a step of 2 or 4 display clocks, plus a 2-bit fine offset of 0 to 3 clocks. A line reset input restarts the horizontal count at the start of every line.

In progressive-scan operation, the memory read enable and the memory write enable can each be suppressed on alternate lines. This is done by ANDing the pulse with a half-line-rate reference, or with the inverse of that reference, chosen per enable. Every setting is captured at a line reset, so a setting written in the middle of a line only takes effect on the next line.

Top module: `disp_line_pulse_gen`

## Requirements
- R1: While `rst_n` is low and after reset is released, all four pulse outputs are 0 until a pulse is programmed and reached.
- R2: Define m as the number of rising clock edges since the edge that sampled `line_reset` high. A pulse with start position S and stop position T, where S < T, is 1 exactly when S < m <= T. With `step_x4` = 0, a position is coarse*2 + fine.
- R3: With `step_x4` = 1, a position is coarse*4 + fine.
- R4: Pulse index i uses the fields `cfg_start[i*9 +: 9]`, `cfg_stop[i*9 +: 9]` and `cfg_fine[i*2 +: 2]`. The indices are 0 blanking, 1 write enable, 2 read enable and 3 display. The fine offset of one pulse does not shift any other pulse.
- R5: When the start and stop coarse values are equal, the pulse stays 0 for the whole line.
- R6: When S > T, the pulse is 1 for m > S, up to the next line reset.
- R7: The edge that samples `line_reset` high forces every output to 0 and restarts the count, even in the middle of a pulse.
- R8: All configuration inputs are sampled only on the edge that samples `line_reset` high. A change during a line has no effect until the next line.
- R9: With `prog_scan` = 1 and `rd_alt_en` = 1, `rd_en_o` is the read pulse ANDed with `half_line_ref`, or with its inverse when `rd_alt_inv` = 1. The reference is sampled on the same edge as the pulse.
- R10: With `prog_scan` = 1 and `wr_alt_en` = 1, `wr_en_o` is the write pulse ANDed with `half_line_ref`, or with its inverse when `wr_alt_inv` = 1.
- R11: When `prog_scan` = 0, or when an enable's alternate-line option is 0, that enable passes through ungated.
- R12: `blank_o` and `disp_o` are never gated by the reference or by the alternate-line options.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_reset | input | 1 | Line start; clears the count and captures the settings |
| step_x4 | input | 1 | Coarse step: 0 = 2 clocks, 1 = 4 clocks |
| cfg_start | input | 36 | Start coarse values, 9 bits per pulse |
| cfg_stop | input | 36 | Stop coarse values, 9 bits per pulse |
| cfg_fine | input | 8 | Fine offsets, 2 bits per pulse |
| prog_scan | input | 1 | Progressive-scan operation |
| rd_alt_en | input | 1 | Gate read enable on alternate lines |
| wr_alt_en | input | 1 | Gate write enable on alternate lines |
| rd_alt_inv | input | 1 | Read gating uses the inverted reference |
| wr_alt_inv | input | 1 | Write gating uses the inverted reference |
| half_line_ref | input | 1 | Half-rate line reference |
| blank_o | output | 1 | Horizontal blanking pulse |
| wr_en_o | output | 1 | Memory write enable |
| rd_en_o | output | 1 | Memory read enable |
| disp_o | output | 1 | Horizontal display pulse |

## Verification
The hardest case to reach from the ports is a setting that changes partway through a line. The outputs must keep following the values captured at the line reset, and then switch over exactly at the next reset. The bench produces this case by rewriting every coarse, fine and option input a few cycles into a line. It keeps its own copy of the values captured at reset and predicts the whole line from that copy. It checks the following line against the new values. A line reset that falls while pulses are still high is brought about by ending a line before the stop positions are reached.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
  localparam int NPULSE = 4;
  localparam int POS_W  = 9;
  localparam int FINE_W = 2;
  localparam int CNT_W  = POS_W + 3;

  localparam int IDX_BLANK = 0;
  localparam int IDX_WRITE = 1;
  localparam int IDX_READ  = 2;
  localparam int IDX_DISP  = 3;

  typedef struct packed {
    logic                       step_x4;
    logic                       prog;
    logic                       rd_alt;
    logic                       wr_alt;
    logic                       rd_inv;
    logic                       wr_inv;
    logic [NPULSE*POS_W-1:0]    start;
    logic [NPULSE*POS_W-1:0]    stop;
    logic [NPULSE*FINE_W-1:0]   fine;
  } line_cfg_t;

  // Edge position in clocks: coarse times step plus fine offset.
  function automatic logic [CNT_W-1:0] edge_pos(input logic [POS_W-1:0] coarse,
                                                input logic [FINE_W-1:0] fine,
                                                input logic x4);
    logic [CNT_W-1:0] base;
    base = x4 ? (CNT_W'(coarse) << 2) : (CNT_W'(coarse) << 1);
    return base + CNT_W'(fine);
  endfunction

  // Gate term for an enable: 1 lets the pulse through.
  function automatic logic alt_gate(input logic active, input logic inv,
                                    input logic ref_in);
    return !active || (ref_in ^ inv);
  endfunction
endpackage

// File: rtl/dlp_line_counter.sv
module dlp_line_counter
  import dlp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_reset,
  output logic [CNT_W-1:0] hcount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic at_max;
  assign at_max = (hcount == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hcount <= '0;
    else if (line_reset) hcount <= '0;
    else if (!at_max)    hcount <= hcount + 1'b1;
  end

  p_count_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_reset && !at_max) |=> (hcount == $past(hcount) + 1'b1));
  p_count_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_reset |=> (hcount == '0));
endmodule

// File: rtl/dlp_line_shadow.sv
module dlp_line_shadow
  import dlp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      line_reset,
  input  line_cfg_t cfg_in,
  output line_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (line_reset) cfg_q <= cfg_in;
  end

  p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_reset |=> $stable(cfg_q));
endmodule

// File: rtl/dlp_pulse_edge.sv
module dlp_pulse_edge
  import dlp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_reset,
  input  logic [CNT_W-1:0] hcount,
  input  logic [CNT_W-1:0] start_pos,
  input  logic [CNT_W-1:0] stop_pos,
  output logic             pulse_next,
  output logic             pulse_q
);
  logic hit_start, hit_stop, empty_pulse;
  assign hit_start   = (hcount == start_pos);
  assign hit_stop    = (hcount == stop_pos);
  assign empty_pulse = (start_pos == stop_pos);

  always_comb begin
    if (line_reset)                    pulse_next = 1'b0;
    else if (hit_start && !empty_pulse) pulse_next = 1'b1;
    else if (hit_stop)                 pulse_next = 1'b0;
    else                               pulse_next = pulse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_next;
  end

  p_empty_stays_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_pulse && !line_reset && !pulse_q) |=> !pulse_q);
  p_line_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_reset |=> !pulse_q);
endmodule

// File: rtl/dlp_out_gate.sv
module dlp_out_gate
  import dlp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_next,
  input  logic gate_active,
  input  logic gate_inv,
  input  logic ref_in,
  output logic out_q
);
  logic pass;
  assign pass = alt_gate(gate_active, gate_inv, ref_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= pulse_next & pass;
  end

  p_alt_line_blocked_r9_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_active && (ref_in == gate_inv)) |=> !out_q);
  p_ungated_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_active && pulse_next) |=> out_q);
endmodule

// File: rtl/disp_line_pulse_gen.sv
module disp_line_pulse_gen
  import dlp_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     line_reset,
  input  logic                     step_x4,
  input  logic [NPULSE*POS_W-1:0]  cfg_start,
  input  logic [NPULSE*POS_W-1:0]  cfg_stop,
  input  logic [NPULSE*FINE_W-1:0] cfg_fine,
  input  logic                     prog_scan,
  input  logic                     rd_alt_en,
  input  logic                     wr_alt_en,
  input  logic                     rd_alt_inv,
  input  logic                     wr_alt_inv,
  input  logic                     half_line_ref,
  output logic                     blank_o,
  output logic                     wr_en_o,
  output logic                     rd_en_o,
  output logic                     disp_o
);
  line_cfg_t         cfg_live, cfg_sh;
  logic [CNT_W-1:0]  hcount;
  logic [NPULSE-1:0] pulse_next, pulse_q, out_vec;
  logic [NPULSE-1:0] gate_active, gate_inv;

  assign cfg_live = '{step_x4: step_x4, prog: prog_scan, rd_alt: rd_alt_en,
                      wr_alt: wr_alt_en, rd_inv: rd_alt_inv, wr_inv: wr_alt_inv,
                      start: cfg_start, stop: cfg_stop, fine: cfg_fine};

  dlp_line_shadow u_shadow (.clk(clk), .rst_n(rst_n), .line_reset(line_reset),
                            .cfg_in(cfg_live), .cfg_q(cfg_sh));

  dlp_line_counter u_count (.clk(clk), .rst_n(rst_n), .line_reset(line_reset),
                            .hcount(hcount));

  always_comb begin
    gate_active = '0;
    gate_inv    = '0;
    gate_active[IDX_READ]  = cfg_sh.prog & cfg_sh.rd_alt;
    gate_inv[IDX_READ]     = cfg_sh.rd_inv;
    gate_active[IDX_WRITE] = cfg_sh.prog & cfg_sh.wr_alt;
    gate_inv[IDX_WRITE]    = cfg_sh.wr_inv;
  end

  for (genvar i = 0; i < NPULSE; i++) begin : g_pulse
    logic [CNT_W-1:0] start_pos, stop_pos;
    assign start_pos = edge_pos(cfg_sh.start[i*POS_W +: POS_W],
                                cfg_sh.fine[i*FINE_W +: FINE_W], cfg_sh.step_x4);
    assign stop_pos  = edge_pos(cfg_sh.stop[i*POS_W +: POS_W],
                                cfg_sh.fine[i*FINE_W +: FINE_W], cfg_sh.step_x4);

    dlp_pulse_edge u_edge (.clk(clk), .rst_n(rst_n), .line_reset(line_reset),
                           .hcount(hcount), .start_pos(start_pos),
                           .stop_pos(stop_pos), .pulse_next(pulse_next[i]),
                           .pulse_q(pulse_q[i]));

    dlp_out_gate u_gate (.clk(clk), .rst_n(rst_n), .pulse_next(pulse_next[i]),
                         .gate_active(gate_active[i]), .gate_inv(gate_inv[i]),
                         .ref_in(half_line_ref), .out_q(out_vec[i]));
  end

  assign blank_o = out_vec[IDX_BLANK];
  assign wr_en_o = out_vec[IDX_WRITE];
  assign rd_en_o = out_vec[IDX_READ];
  assign disp_o  = out_vec[IDX_DISP];

  p_never_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_active[IDX_BLANK] == 1'b0) && (gate_active[IDX_DISP] == 1'b0));
  p_outputs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_reset |=> (out_vec == '0));
endmodule

// File: tb/test_disp_line_pulse_gen.sv
module test_disp_line_pulse_gen;
  logic clk = 1'b0, rst_n = 1'b0, line_reset = 1'b0, step_x4 = 1'b0;
  logic [35:0] cfg_start, cfg_stop;
  logic [7:0]  cfg_fine;
  logic prog_scan = 0, rd_alt_en = 0, wr_alt_en = 0, rd_alt_inv = 0, wr_alt_inv = 0;
  logic half_line_ref = 0;
  logic blank_o, wr_en_o, rd_en_o, disp_o;

  int st[4], sp[4], fn[4];
  int c_st[4], c_sp[4], c_fn[4];
  logic c_x4, c_prog, c_rda, c_wra, c_rdi, c_wri;
  int vectors = 0, misses = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < 4; i++) begin
      cfg_start[i*9 +: 9] = 9'(st[i]);
      cfg_stop[i*9 +: 9]  = 9'(sp[i]);
      cfg_fine[i*2 +: 2]  = 2'(fn[i]);
    end

  disp_line_pulse_gen i_disp_line_pulse_gen (.*);

  task automatic check(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Independent model: ungated level of pulse i after edge m of the line.
  function automatic logic model_pulse(input int i, input int m);
    int mul, s, t;
    mul = c_x4 ? 4 : 2;
    s = c_st[i] * mul + c_fn[i];
    t = c_sp[i] * mul + c_fn[i];
    if (s == t) return 1'b0;
    if (s < t)  return (m > s) && (m <= t);
    return m > s;
  endfunction

  task automatic set_pulse(input int i, input int a, input int b, input int f);
    st[i] = a; sp[i] = b; fn[i] = f;
  endtask

  // One line of length len; chg rewrites all settings at edge 2 of the line.
  task automatic run_line(input int len, input logic ref_v, input bit chg, input string req);
    logic rg, wg;
    @(negedge clk);
    half_line_ref = ref_v;
    line_reset = 1'b1;
    c_x4 = step_x4; c_prog = prog_scan; c_rda = rd_alt_en; c_wra = wr_alt_en;
    c_rdi = rd_alt_inv; c_wri = wr_alt_inv;
    for (int i = 0; i < 4; i++) begin c_st[i] = st[i]; c_sp[i] = sp[i]; c_fn[i] = fn[i]; end
    @(posedge clk);
    @(negedge clk);
    line_reset = 1'b0;
    check({blank_o, wr_en_o, rd_en_o, disp_o} == 4'b0, 1'b1, "R7", "outputs at line start");
    rg = !(c_prog && c_rda) || (ref_v ^ c_rdi);
    wg = !(c_prog && c_wra) || (ref_v ^ c_wri);
    for (int m = 1; m <= len; m++) begin
      @(posedge clk);
      @(negedge clk);
      check(blank_o, model_pulse(0, m), req, "blank_o");
      check(wr_en_o, model_pulse(1, m) & wg, req, "wr_en_o");
      check(rd_en_o, model_pulse(2, m) & rg, req, "rd_en_o");
      check(disp_o,  model_pulse(3, m), req, "disp_o");
      if (chg && m == 2) begin
        for (int i = 0; i < 4; i++) set_pulse(i, 1, 3 + i, 3 - i);
        step_x4 = ~step_x4; prog_scan = 1; rd_alt_en = 1; wr_alt_en = 1;
        rd_alt_inv = ~rd_alt_inv;
      end
    end
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) set_pulse(i, 0, 2, 0);
    #3;
    check({blank_o, wr_en_o, rd_en_o, disp_o} == 4'b0, 1'b1, "R1", "outputs in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({blank_o, wr_en_o, rd_en_o, disp_o} == 4'b0, 1'b1, "R1", "outputs after reset");
  endtask

  task automatic t_step2;
    step_x4 = 0; prog_scan = 0;
    set_pulse(0, 2, 20, 0); set_pulse(1, 3, 9, 1);
    set_pulse(2, 5, 12, 2); set_pulse(3, 1, 25, 3);
    run_line(60, 1'b1, 0, "R2");
    set_pulse(0, 2, 20, 3); set_pulse(1, 3, 9, 0);
    run_line(60, 1'b0, 0, "R4");
  endtask

  task automatic t_step4;
    step_x4 = 1;
    set_pulse(0, 1, 10, 2); set_pulse(1, 4, 6, 3);
    set_pulse(2, 2, 15, 1); set_pulse(3, 0, 18, 0);
    run_line(80, 1'b1, 0, "R3");
  endtask

  task automatic t_corner;
    step_x4 = 0;
    set_pulse(0, 7, 7, 1); set_pulse(1, 9, 9, 0);
    set_pulse(2, 4, 4, 3); set_pulse(3, 12, 12, 2);
    run_line(40, 1'b1, 0, "R5");
    set_pulse(0, 15, 4, 0); set_pulse(1, 10, 2, 1);
    set_pulse(2, 8, 1, 2);  set_pulse(3, 18, 3, 3);
    run_line(45, 1'b1, 0, "R6");
    set_pulse(0, 2, 40, 0); set_pulse(1, 2, 40, 1);
    set_pulse(2, 2, 40, 2); set_pulse(3, 2, 40, 3);
    run_line(20, 1'b1, 0, "R7");
    run_line(20, 1'b1, 0, "R7");
  endtask

  task automatic t_midline;
    step_x4 = 0; prog_scan = 0; rd_alt_en = 0; wr_alt_en = 0; rd_alt_inv = 0;
    set_pulse(0, 3, 14, 1); set_pulse(1, 2, 11, 2);
    set_pulse(2, 6, 16, 0); set_pulse(3, 4, 20, 3);
    run_line(50, 1'b0, 1, "R8");
    run_line(50, 1'b0, 0, "R8");
  endtask

  task automatic t_alt_gate;
    step_x4 = 0; prog_scan = 1;
    for (int i = 0; i < 4; i++) set_pulse(i, 2 + i, 14 + i, i);
    rd_alt_en = 1; wr_alt_en = 0; rd_alt_inv = 0;
    run_line(40, 1'b0, 0, "R9");
    run_line(40, 1'b1, 0, "R9");
    rd_alt_inv = 1;
    run_line(40, 1'b0, 0, "R9");
    run_line(40, 1'b1, 0, "R9");
    rd_alt_en = 0; wr_alt_en = 1; wr_alt_inv = 0;
    run_line(40, 1'b0, 0, "R10");
    run_line(40, 1'b1, 0, "R10");
    wr_alt_inv = 1;
    run_line(40, 1'b1, 0, "R10");
    rd_alt_en = 1; rd_alt_inv = 1; wr_alt_inv = 1;
    run_line(40, 1'b1, 0, "R12");
    run_line(40, 1'b0, 0, "R12");
    prog_scan = 0;
    run_line(40, 1'b1, 0, "R11");
    run_line(40, 1'b0, 0, "R11");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) set_pulse(i, 0, 0, 0);
    t_reset();
    t_step2();
    t_step4();
    t_corner();
    t_midline();
    t_alt_gate();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule